// File: doc/BRIEF.md
# CMOS Clock Register Port

This block is the host-facing side of a PC-style real-time clock. A host reaches fourteen clock bytes through two addresses: a write to the even address selects a byte, and a write or read at the odd address reaches the selected byte. The bank holds the seven time bytes, three alarm bytes and four control/status bytes. It applies each register's side effects as the access happens. It also raises a level interrupt from the status register.

The per-second counting engine and the periodic rate divider are not part of this block. They attach through single-cycle strobes. `upd_begin` and `upd_end` frame an update cycle. `evt_flags` reports periodic, alarm and update events. The block answers with `clk_reload`, a one-cycle pulse that tells the engine to load its running time from `time_regs`.

Byte map (index: content): 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday, 7 day of month, 8 month, 9 year, 10 control A, 11 control B, 12 status C, 13 status D. Indices 0, 2, 4, 6, 7, 8 and 9 are the time bytes.

The control bits used are:
- A bit 7: update-in-progress (UIP).
- B bit 7: SET.
- B bit 4: update-interrupt enable.
- C bit 7: interrupt request.
- C bit 6: periodic flag.
- C bit 5: alarm flag.
- C bit 4: update flag.

Top module: `cmos_rtc_port`

## Requirements
- R1: A write with `addr`=0 loads the index with `wdata[6:0]`, so 0x8D selects index 13. A read with `addr`=0 returns 0xFF.
- R2: Data-port accesses (`addr`=1) to indices 14 and above have no effect: no byte changes and `clk_reload` stays low. A read there returns 0xFF.
- R3: After reset the bytes read as follows: A = 0x26, B = 0x02, C = 0x00, D = 0x80, and every time and alarm byte = 0x00. `irq` and `clk_reload` are low.
- R4: A write to register A stores bits 6:0 and keeps the current value of bit 7 (UIP).
- R5: A write to register B with bit 7 (SET) = 1 clears A bit 7 and stores the written value with bit 4 forced to 0.
- R6: A write to register B with SET = 0 while the stored SET is 1 pulses `clk_reload` for one cycle, starting on the cycle after the write.
- R7: A write to a time byte stores the value. When the stored SET is 0, the write also pulses `clk_reload` on the cycle after the write. A write to an alarm byte only stores the value.
- R8: Writes to registers C (index 12) and D (index 13) have no effect.
- R9: A data-port read of register C returns its current value. The register then becomes 0x00 and `irq` goes low on the next cycle, unless an event arrives in the same cycle.
- R10: An `evt_flags` pulse sets bits 6:4 of C: `evt_flags[2]` sets the periodic flag, `[1]` the alarm flag and `[0]` the update flag. The pulse also sets C bit 7. `irq` follows C bit 7.
- R11: `upd_begin` sets A bit 7 when the stored SET is 0. `upd_end` clears A bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| addr | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and index |
| evt_flags | input | 3 | Event strobes: periodic, alarm, update |
| upd_begin | input | 1 | Update cycle starts |
| upd_end | input | 1 | Update cycle ends |
| time_regs | output | 56 | Time bytes, packed in index order, index 0 in bits 7:0 |
| clk_reload | output | 1 | One-cycle request to reload the running clock |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker watches invariants that hold on every cycle:
- `irq` changes only through a status read or an event.
- A read of C leaves `irq` low.
- The UIP bit survives writes to A.
- Set-mode entry clears UIP.
- Ignored data-port writes leave the bank stable.
- Every reload pulse traces back to a qualifying write.

The bench's scenarios cover what needs the exact values:
- index masking;
- the reset bytes;
- the stored form of B;
- reload only on time bytes and only outside set mode;
- the flag bits that events place in C.

// File: rtl/cmos_rtc_pkg.sv
package cmos_rtc_pkg;
  localparam int DW     = 8;
  localparam int IDX_W  = 7;
  localparam int NREG   = 14;
  localparam int NTIME  = 10;
  localparam int SEL_W  = $clog2(NREG);

  localparam logic [IDX_W-1:0] IX_LIMIT = IDX_W'(NREG);
  localparam logic [SEL_W-1:0] IX_A = SEL_W'(10);
  localparam logic [SEL_W-1:0] IX_B = SEL_W'(11);
  localparam logic [SEL_W-1:0] IX_C = SEL_W'(12);
  localparam logic [SEL_W-1:0] IX_D = SEL_W'(13);

  localparam int BIT_UIP  = 7;
  localparam int BIT_SET  = 7;
  localparam int BIT_UIEN = 4;
  localparam int BIT_IRQF = 7;

  function automatic logic [DW-1:0] rst_val(input int i);
    case (i)
      10:      rst_val = 8'h26;
      11:      rst_val = 8'h02;
      13:      rst_val = 8'h80;
      default: rst_val = 8'h00;
    endcase
  endfunction

  function automatic logic is_time(input logic [SEL_W-1:0] i);
    is_time = (i == 4'd0) || (i == 4'd2) || (i == 4'd4) ||
              (i == 4'd6) || (i == 4'd7) || (i == 4'd8) || (i == 4'd9);
  endfunction
endpackage

// File: rtl/cmos_idx_latch.sv
module cmos_idx_latch
  import cmos_rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [DW-1:0]    wdata,
  output logic [IDX_W-1:0] idx_q
);
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (load_en) idx_d = wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/cmos_reg_bank.sv
module cmos_reg_bank
  import cmos_rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             rd_stat,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    wdata,
  input  logic [2:0]       evt_flags,
  input  logic             upd_begin,
  input  logic             upd_end,
  output logic [NREG*DW-1:0] bank_flat,
  output logic             clk_reload,
  output logic             irq
);
  logic [DW-1:0] mem_q [NREG];
  logic [DW-1:0] mem_d [NREG];
  logic          reload_d;
  logic          set_q;

  assign set_q = mem_q[IX_B][BIT_SET];

  always_comb begin
    for (int i = 0; i < NREG; i++) mem_d[i] = mem_q[i];
    reload_d = 1'b0;

    if (upd_begin && !set_q) mem_d[IX_A][BIT_UIP] = 1'b1;
    if (upd_end)             mem_d[IX_A][BIT_UIP] = 1'b0;

    if (wr_hit) begin
      if (is_time(sel)) begin
        mem_d[sel] = wdata;
        if (!set_q) reload_d = 1'b1;
      end else if (sel == IX_A) begin
        mem_d[IX_A] = {mem_d[IX_A][BIT_UIP], wdata[DW-2:0]};
      end else if (sel == IX_B) begin
        if (wdata[BIT_SET]) begin
          mem_d[IX_A][BIT_UIP] = 1'b0;
          mem_d[IX_B] = wdata & ~(8'h01 << BIT_UIEN);
        end else begin
          mem_d[IX_B] = wdata;
          if (set_q) reload_d = 1'b1;
        end
      end else if (sel != IX_C && sel != IX_D) begin
        mem_d[sel] = wdata;
      end
    end

    if (rd_stat) mem_d[IX_C] = '0;
    if (|evt_flags) mem_d[IX_C] = mem_d[IX_C] | {1'b1, evt_flags, 4'h0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= rst_val(i);
      clk_reload <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
      clk_reload <= reload_d;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign bank_flat[g*DW +: DW] = mem_q[g];
  end

  assign irq = mem_q[IX_C][BIT_IRQF];
endmodule

// File: rtl/cmos_rd_mux.sv
module cmos_rd_mux
  import cmos_rtc_pkg::*;
(
  input  logic               addr,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NREG*DW-1:0] bank_flat,
  output logic [DW-1:0]      rdata
);
  always_comb begin
    if (!addr || idx >= IX_LIMIT) rdata = '1;
    else                          rdata = bank_flat[int'(idx)*DW +: DW];
  end
endmodule

// File: rtl/cmos_rtc_port.sv
module cmos_rtc_port
  import cmos_rtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic                addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  input  logic [2:0]          evt_flags,
  input  logic                upd_begin,
  input  logic                upd_end,
  output logic [7*DW-1:0]     time_regs,
  output logic                clk_reload,
  output logic                irq
);
  logic [1:0]         rst_sync;
  logic               rst_sn;
  logic [IDX_W-1:0]   idx_q;
  logic               in_range;
  logic               wr_hit;
  logic               rd_stat;
  logic [NREG*DW-1:0] bank_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sn = rst_sync[1];

  assign in_range = (idx_q < IX_LIMIT);
  assign wr_hit   = wr_en && addr && in_range;
  assign rd_stat  = rd_en && addr && in_range && (idx_q[SEL_W-1:0] == IX_C);

  cmos_idx_latch u_idx (
    .clk(clk), .rst_n(rst_sn), .load_en(wr_en && !addr),
    .wdata(wdata), .idx_q(idx_q)
  );

  cmos_reg_bank u_bank (
    .clk(clk), .rst_n(rst_sn), .wr_hit(wr_hit), .rd_stat(rd_stat),
    .sel(idx_q[SEL_W-1:0]), .wdata(wdata), .evt_flags(evt_flags),
    .upd_begin(upd_begin), .upd_end(upd_end), .bank_flat(bank_flat),
    .clk_reload(clk_reload), .irq(irq)
  );

  cmos_rd_mux u_rd (
    .addr(addr), .idx(idx_q), .bank_flat(bank_flat), .rdata(rdata)
  );

  assign time_regs = {bank_flat[9*DW +: DW], bank_flat[8*DW +: DW],
                      bank_flat[7*DW +: DW], bank_flat[6*DW +: DW],
                      bank_flat[4*DW +: DW], bank_flat[2*DW +: DW],
                      bank_flat[0 +: DW]};
endmodule

// File: rtl/cmos_rtc_port_chk.sv
module cmos_rtc_port_chk
  import cmos_rtc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               rd_en,
  input logic               addr,
  input logic [DW-1:0]      wdata,
  input logic [IDX_W-1:0]   idx_q,
  input logic [NREG*DW-1:0] bank_flat,
  input logic [2:0]         evt_flags,
  input logic               upd_begin,
  input logic               upd_end,
  input logic               clk_reload,
  input logic               irq
);
  logic quiet;
  assign quiet = !(|evt_flags) && !upd_begin && !upd_end;

  // R2
  oob_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && idx_q >= IX_LIMIT && quiet) |=> $stable(bank_flat));

  // R8
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && (idx_q == 7'd12 || idx_q == 7'd13) && quiet)
      |=> $stable(bank_flat));

  // R4
  uip_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && idx_q == 7'd10 && quiet)
      |=> $stable(bank_flat[10*DW + BIT_UIP]));

  // R5
  set_clears_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && idx_q == 7'd11 && wdata[BIT_SET])
      |=> !bank_flat[10*DW + BIT_UIP] && !bank_flat[11*DW + BIT_UIEN]);

  // R6 R7
  reload_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_reload) |-> $past(wr_en && addr));

  // R9
  stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr && idx_q == 7'd12 && !(|evt_flags)) |=> !irq);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|evt_flags) && !(rd_en && addr && idx_q == 7'd12)) |=> $stable(irq));

  // R10
  event_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_flags) |=> irq);
endmodule

bind cmos_rtc_port cmos_rtc_port_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .idx_q(idx_q), .bank_flat(bank_flat), .evt_flags(evt_flags),
  .upd_begin(upd_begin), .upd_end(upd_end), .clk_reload(clk_reload), .irq(irq)
);

// File: tb/cmos_rtc_port_tb.sv
module cmos_rtc_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] evt_flags = 3'b000;
  logic       upd_begin = 1'b0, upd_end = 1'b0;
  logic [55:0] time_regs;
  logic       clk_reload, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmos_rtc_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_flags(evt_flags),
    .upd_begin(upd_begin), .upd_end(upd_end), .time_regs(time_regs),
    .clk_reload(clk_reload), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
    @(posedge clk); #1; rd_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [6:0] i, input string tag, input logic [7:0] exp);
    logic [7:0] v;
    wr(1'b0, {1'b0, i});
    rd(1'b1, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input logic [2:0] e, input logic ub, input logic ue);
    @(negedge clk); evt_flags = e; upd_begin = ub; upd_end = ue;
    @(posedge clk); #1; evt_flags = 3'b000; upd_begin = 1'b0; upd_end = 1'b0;
  endtask

  task automatic t_reset;
    chk("R3 irq", irq, 1'b0);
    chk("R3 reload", clk_reload, 1'b0);
    chk("R3 time_regs", time_regs, 56'h0);
    rd_reg(7'd10, "R3 A", 8'h26);
    rd_reg(7'd11, "R3 B", 8'h02);
    rd_reg(7'd12, "R3 C", 8'h00);
    rd_reg(7'd13, "R3 D", 8'h80);
    rd_reg(7'd3,  "R3 alarm", 8'h00);
  endtask

  task automatic t_index;
    logic [7:0] v;
    wr(1'b0, 8'h8D);
    rd(1'b1, v); chk("R1 masked index reads D", v, 8'h80);
    rd(1'b0, v); chk("R1 index port read", v, 8'hFF);
  endtask

  task automatic t_oob;
    logic [7:0] v;
    wr(1'b0, 8'h0E);
    wr(1'b1, 8'h55); chk("R2 no reload", clk_reload, 1'b0);
    rd(1'b1, v); chk("R2 read oob", v, 8'hFF);
    wr(1'b0, 8'h7F);
    wr(1'b1, 8'hAA);
    rd_reg(7'd0,  "R2 sec untouched", 8'h00);
    rd_reg(7'd10, "R2 A untouched", 8'h26);
  endtask

  task automatic t_uip;
    pulse(3'b000, 1'b1, 1'b0);
    rd_reg(7'd10, "R11 UIP set", 8'hA6);
    wr(1'b1, 8'h05);
    rd_reg(7'd10, "R4 UIP kept on write", 8'h85);
    pulse(3'b000, 1'b0, 1'b1);
    rd_reg(7'd10, "R11 UIP cleared", 8'h05);
  endtask

  task automatic t_setmode;
    pulse(3'b000, 1'b1, 1'b0);
    wr(1'b0, 8'h0B);
    wr(1'b1, 8'h92);
    rd_reg(7'd11, "R5 B stored without UIE", 8'h82);
    rd_reg(7'd10, "R5 UIP cleared", 8'h05);
    pulse(3'b000, 1'b1, 1'b0);
    rd_reg(7'd10, "R11 UIP held off in set mode", 8'h05);
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h30); chk("R7 no reload in set mode", clk_reload, 1'b0);
    wr(1'b0, 8'h0B);
    wr(1'b1, 8'h02); chk("R6 reload on leaving set", clk_reload, 1'b1);
    @(posedge clk); #1; chk("R6 single pulse", clk_reload, 1'b0);
    chk("R7 time_regs sec", time_regs[7:0], 8'h30);
    wr(1'b1, 8'h02); chk("R6 no reload without prior SET", clk_reload, 1'b0);
  endtask

  task automatic t_time;
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h15); chk("R7 reload on time write", clk_reload, 1'b1);
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h44); chk("R7 alarm no reload", clk_reload, 1'b0);
    rd_reg(7'd1, "R7 alarm stored", 8'h44);
    chk("R7 minutes in time_regs", time_regs[15:8], 8'h15);
  endtask

  task automatic t_status_wr;
    wr(1'b0, 8'h0C); wr(1'b1, 8'hFF);
    wr(1'b0, 8'h0D); wr(1'b1, 8'h00);
    rd_reg(7'd12, "R8 C unchanged", 8'h00);
    rd_reg(7'd13, "R8 D unchanged", 8'h80);
    chk("R8 irq low", irq, 1'b0);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    pulse(3'b010, 1'b0, 1'b0);
    chk("R10 irq raised", irq, 1'b1);
    wr(1'b0, 8'h0C);
    rd(1'b1, v); chk("R9 C read value", v, 8'hA0);
    chk("R9 irq dropped", irq, 1'b0);
    rd(1'b1, v); chk("R9 C cleared", v, 8'h00);
    pulse(3'b101, 1'b0, 1'b0);
    rd(1'b1, v); chk("R10 periodic+update flags", v, 8'hD0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_index();
    t_oob();
    t_uip();
    t_setmode();
    t_time();
    t_status_wr();
    t_irq();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule